// File: doc/BRIEF.md
# Indirect SDRAM Bank Configuration Registers

This block is the control-register front end of a four-bank memory controller. Software reaches it over a 32-bit device-control register bus through two register numbers: one latches an internal offset, the other reads or writes the internal register that the latched offset selects. Behind that pair sit the global configuration and status words, the refresh and power-management timers, the bus error status and error address words, the ECC configuration and ECC error status words, and one control word per bank.

Each bank word packs an enable bit, a base address and a power-of-two size code. The block compares a system address against every bank word and reports, one-hot, the bank it falls in, with the lowest-numbered bank taking precedence on overlap. Decoding is gated by the global enable bit of the configuration word, whose edges also update the status word. A level interrupt output is high exactly while the ECC error status word holds a nonzero value.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write to register number 0x010 latches all 32 bits of wdata as the internal offset; a read of 0x010 returns that offset; a read or write of 0x011 accesses the internal register the offset selects; a read of any other register number returns 0 and a write to any other register number changes nothing. Read data appears on rdata_o on the cycle after the read strobe and holds until the next read strobe.
- R2: Internal offsets are 0x00 and 0x08 (error status 0 and 1), 0x10 (error address), 0x20 (config), 0x24 (status), 0x30 (refresh timer), 0x34 (power timer), 0x40 + 4*n (bank n control, n = 0..3), 0x94 (ECC config), 0x98 (ECC error status). Offset 0x80 and every offset not listed read as 0xFFFFFFFF.
- R3: A bank control word stores the written value ANDed with 0xFFDEE001; bit 0 is the bank enable, bits 31:23 the base address (bits 22:0 of the base are zero), bits 19:17 the size code; bank size is 4 MiB shifted left by the code, and code 7 marks an invalid size.
- R4: Config writes store the value ANDed with 0xFFE00000. A write that takes config bit 31 from 0 to 1 clears status bit 31; a write that takes it from 1 to 0 sets status bit 31.
- R5: A write that takes config bit 30 from 0 to 1 sets status bit 30; one that takes it from 1 to 0 clears status bit 30.
- R6: The status word changes only through R4 and R5; writes to offset 0x24 are ignored. Error status 0 and 1 are write-one-to-clear; the error address word stores the written value unchanged.
- R7: Refresh timer writes store value AND 0x3FF80000; power timer writes store (value AND 0xF8000000) OR 0x07C00000; ECC config writes store value AND 0x00F00000.
- R8: ECC error status writes store value AND 0xFFF0F000; ecc_irq_o is 1 exactly while that stored value is nonzero, rising on a zero-to-nonzero write and falling on a nonzero-to-zero write.
- R9: After reset: offset 0, config 0x00800000, status 0, refresh timer 0x05F00000, power timer 0x07C00000, error, ECC and bank words 0, ecc_irq_o 0, hit_o 0.
- R10: hit_o[n] can be 1 only when config bit 31 is 1, bank n's enable bit is 1, its size code is not 7, and base <= sys_addr_i < base + size.
- R11: When several banks match, only the lowest-numbered matching bank's hit_o bit is 1; hit_o is never more than one-hot.
- R12: hit_o is combinational from sys_addr_i and the stored words, so a bank or config write is reflected in hit_o in the cycle right after its write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Single-cycle read strobe |
| wr_i | input | 1 | Single-cycle write strobe |
| regno_i | input | 10 | Bus register number |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| sys_addr_i | input | 32 | System address to decode |
| hit_o | output | 4 | One-hot bank hit |
| ecc_irq_o | output | 1 | ECC error interrupt level |

## Verification
Register state and ecc_irq_o settle at the clock edge that samples the write strobe, so the bench drives strobes on the falling edge and checks on the following falling edge. Read data is due one edge after the read strobe and is sampled on the falling edge after that edge. hit_o depends combinationally on sys_addr_i and stored words, so it is checked a quarter period after the address changes, and right after a bank write returns, with no added wait, to show the single-cycle update.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  typedef logic [31:0] word_t;

  localparam word_t OFF_ESR0  = 32'h0000_0000;
  localparam word_t OFF_ESR1  = 32'h0000_0008;
  localparam word_t OFF_EADR  = 32'h0000_0010;
  localparam word_t OFF_CFG   = 32'h0000_0020;
  localparam word_t OFF_STS   = 32'h0000_0024;
  localparam word_t OFF_RTR   = 32'h0000_0030;
  localparam word_t OFF_PMT   = 32'h0000_0034;
  localparam word_t OFF_BANK0 = 32'h0000_0040;
  localparam word_t OFF_ECFG  = 32'h0000_0094;
  localparam word_t OFF_EESR  = 32'h0000_0098;
  localparam int unsigned BANK_STRIDE = 4;

  localparam word_t CFG_MASK  = 32'hFFE0_0000;
  localparam word_t RTR_MASK  = 32'h3FF8_0000;
  localparam word_t PMT_MASK  = 32'hF800_0000;
  localparam word_t PMT_FIXED = 32'h07C0_0000;
  localparam word_t ECFG_MASK = 32'h00F0_0000;
  localparam word_t EESR_MASK = 32'hFFF0_F000;
  localparam word_t BANK_MASK = 32'hFFDE_E001;

  localparam word_t CFG_RST = 32'h0080_0000;
  localparam word_t RTR_RST = 32'h05F0_0000;
  localparam word_t PMT_RST = 32'h07C0_0000;

  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned SELF_BIT = 30;

  localparam int unsigned BASE_LSB = 23;
  localparam int unsigned BASE_W   = 32 - BASE_LSB;
  localparam int unsigned CODE_LSB = 17;
  localparam int unsigned CODE_W   = 3;
  localparam logic [CODE_W-1:0] CODE_BAD = 3'd7;
  localparam int unsigned MIN_SIZE_LOG2 = 22;

  function automatic word_t bank_off(input int unsigned b);
    return OFF_BANK0 + word_t'(BANK_STRIDE * b);
  endfunction
endpackage

// File: rtl/sdram_cfg_port.sv
module sdram_cfg_port
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned REGNO_W = 10,
  parameter logic [REGNO_W-1:0] ADDR_REGNO = 10'h010,
  parameter logic [REGNO_W-1:0] DATA_REGNO = 10'h011
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [REGNO_W-1:0] regno_i,
  input  word_t              wdata_i,
  input  word_t              rval_i,
  output word_t              off_o,
  output logic               dwe_o,
  output word_t              rdata_o
);
  word_t off_q, rdata_q;
  logic  sel_addr, sel_data;

  assign sel_addr = (regno_i == ADDR_REGNO);
  assign sel_data = (regno_i == DATA_REGNO);
  assign dwe_o    = wr_i && sel_data;
  assign off_o    = off_q;
  assign rdata_o  = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_i && sel_addr) off_q <= wdata_i;
      if (rd_i) begin
        if (sel_addr)      rdata_q <= off_q;
        else if (sel_data) rdata_q <= rval_i;
        else               rdata_q <= '0;
      end
    end
  end

  // R1: read data only moves after a read strobe
  a_r1_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> $stable(rdata_o));
  // R1: offset only moves after a write to the address register
  a_r1_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) |-> $stable(off_o));
endmodule

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  word_t                      off_i,
  input  word_t                      wdata_i,
  output word_t                      rval_o,
  output logic                       cfg_en_o,
  output logic [NUM_BANKS-1:0][31:0] bank_o,
  output logic                       irq_o
);
  word_t esr0_q, esr1_q, eadr_q, cfg_q, sts_q, rtr_q, pmt_q, ecfg_q, eesr_q;
  logic [NUM_BANKS-1:0][31:0] bank_q;
  logic  irq_q;
  word_t cfg_wr, eesr_wr;

  assign cfg_wr   = wdata_i & CFG_MASK;
  assign eesr_wr  = wdata_i & EESR_MASK;
  assign cfg_en_o = cfg_q[EN_BIT];
  assign bank_o   = bank_q;
  assign irq_o    = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esr0_q <= '0;
      esr1_q <= '0;
      eadr_q <= '0;
      cfg_q  <= CFG_RST;
      sts_q  <= '0;
      rtr_q  <= RTR_RST;
      pmt_q  <= PMT_RST;
      ecfg_q <= '0;
      eesr_q <= '0;
      irq_q  <= 1'b0;
    end else if (we_i) begin
      case (off_i)
        OFF_ESR0: esr0_q <= esr0_q & ~wdata_i;
        OFF_ESR1: esr1_q <= esr1_q & ~wdata_i;
        OFF_EADR: eadr_q <= wdata_i;
        OFF_CFG: begin
          if (!cfg_q[EN_BIT] && cfg_wr[EN_BIT])      sts_q[EN_BIT] <= 1'b0;
          else if (cfg_q[EN_BIT] && !cfg_wr[EN_BIT]) sts_q[EN_BIT] <= 1'b1;
          if (!cfg_q[SELF_BIT] && cfg_wr[SELF_BIT])      sts_q[SELF_BIT] <= 1'b1;
          else if (cfg_q[SELF_BIT] && !cfg_wr[SELF_BIT]) sts_q[SELF_BIT] <= 1'b0;
          cfg_q <= cfg_wr;
        end
        OFF_RTR:  rtr_q  <= wdata_i & RTR_MASK;
        OFF_PMT:  pmt_q  <= (wdata_i & PMT_MASK) | PMT_FIXED;
        OFF_ECFG: ecfg_q <= wdata_i & ECFG_MASK;
        OFF_EESR: begin
          eesr_q <= eesr_wr;
          irq_q  <= |eesr_wr;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
    end else if (we_i) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (off_i == bank_off(b)) bank_q[b] <= wdata_i & BANK_MASK;
      end
    end
  end

  always_comb begin
    rval_o = '1;
    case (off_i)
      OFF_ESR0: rval_o = esr0_q;
      OFF_ESR1: rval_o = esr1_q;
      OFF_EADR: rval_o = eadr_q;
      OFF_CFG:  rval_o = cfg_q;
      OFF_STS:  rval_o = sts_q;
      OFF_RTR:  rval_o = rtr_q;
      OFF_PMT:  rval_o = pmt_q;
      OFF_ECFG: rval_o = ecfg_q;
      OFF_EESR: rval_o = eesr_q;
      default:  ;
    endcase
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (off_i == bank_off(b)) rval_o = bank_q[b];
    end
  end

  // R8: interrupt level tracks nonzero ECC error status
  a_r8_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == (eesr_q != '0));
  // R4: disable edge leaves status bit 31 set
  a_r4_sts_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_q[EN_BIT]) |-> sts_q[EN_BIT]);
  // R4: enable edge leaves status bit 31 clear
  a_r4_sts_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_q[EN_BIT]) |-> !sts_q[EN_BIT]);
  // R6: status moves only with a config bit edge
  a_r6_sts_only_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sts_q) |-> !$stable(cfg_q[EN_BIT:SELF_BIT]));
  // R7: power timer fixed field always reads as ones
  a_r7_pmt_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmt_q & ~PMT_MASK) == PMT_FIXED);
endmodule

// File: rtl/sdram_bank_dec.sv
module sdram_bank_dec
  import sdram_cfg_pkg::*;
(
  input  logic              en_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [CODE_W-1:0] code_i,
  input  word_t             addr_i,
  output logic              match_o
);
  localparam int unsigned EXT_W = 33;
  logic [EXT_W-1:0] base_ext, size_ext, limit_ext, addr_ext;
  logic             ge_base, lt_limit;

  assign base_ext  = {1'b0, base_i, {BASE_LSB{1'b0}}};
  assign size_ext  = {{(EXT_W-1){1'b0}}, 1'b1} << (MIN_SIZE_LOG2 + 32'(code_i));
  assign limit_ext = base_ext + size_ext;
  assign addr_ext  = {1'b0, addr_i};
  assign ge_base   = addr_ext >= base_ext;
  assign lt_limit  = addr_ext < limit_ext;
  assign match_o   = en_i && (code_i != CODE_BAD) && ge_base && lt_limit;
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned REGNO_W = 10,
  parameter logic [REGNO_W-1:0] ADDR_REGNO = 10'h010,
  parameter logic [REGNO_W-1:0] DATA_REGNO = 10'h011
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [REGNO_W-1:0]   regno_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [31:0]          sys_addr_i,
  output logic [NUM_BANKS-1:0] hit_o,
  output logic                 ecc_irq_o
);
  word_t off, rval;
  logic  dwe, cfg_en;
  logic [NUM_BANKS-1:0][31:0] bank;
  logic [NUM_BANKS-1:0] match;

  sdram_cfg_port #(
    .REGNO_W(REGNO_W), .ADDR_REGNO(ADDR_REGNO), .DATA_REGNO(DATA_REGNO)
  ) u_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i),
    .regno_i(regno_i), .wdata_i(wdata_i), .rval_i(rval),
    .off_o(off), .dwe_o(dwe), .rdata_o(rdata_o)
  );

  sdram_cfg_regfile #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(dwe), .off_i(off),
    .wdata_i(wdata_i), .rval_o(rval), .cfg_en_o(cfg_en),
    .bank_o(bank), .irq_o(ecc_irq_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    sdram_bank_dec u_dec (
      .en_i(cfg_en && bank[b][0]),
      .base_i(bank[b][31:BASE_LSB]),
      .code_i(bank[b][CODE_LSB +: CODE_W]),
      .addr_i(sys_addr_i),
      .match_o(match[b])
    );
  end

  // lowest-numbered matching bank wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    hit_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (match[b] && !taken) begin
        hit_o[b] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  // R11: never more than one bank reported
  a_r11_hit_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));
  // R10: global disable suppresses every hit
  a_r10_off_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en |-> (hit_o == '0));
endmodule

// File: tb/tb_sdram_cfg_regs.sv
module tb_sdram_cfg_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] RA = 10'h010;
  localparam logic [9:0] RD = 10'h011;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [9:0]  regno_i = '0;
  logic [31:0] wdata_i = '0, sys_addr_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  hit_o;
  logic        ecc_irq_o;

  int vecs = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_esr0, m_esr1, m_eadr, m_cfg, m_sts, m_rtr, m_pmt, m_ecfg, m_eesr;
  logic [31:0] m_bank [4];

  sdram_cfg_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .regno_i(regno_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .sys_addr_i(sys_addr_i),
    .hit_o(hit_o), .ecc_irq_o(ecc_irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_esr0 = 0; m_esr1 = 0; m_eadr = 0; m_cfg = 32'h0080_0000; m_sts = 0;
    m_rtr = 32'h05F0_0000; m_pmt = 32'h07C0_0000; m_ecfg = 0; m_eesr = 0;
    for (int b = 0; b < 4; b++) m_bank[b] = 0;
  endtask

  task automatic model_wr(input logic [31:0] off, input logic [31:0] v);
    logic [31:0] n;
    case (off)
      32'h00: m_esr0 &= ~v;
      32'h08: m_esr1 &= ~v;
      32'h10: m_eadr = v;
      32'h20: begin
        n = v & 32'hFFE0_0000;
        if (!m_cfg[31] && n[31]) m_sts[31] = 0; else if (m_cfg[31] && !n[31]) m_sts[31] = 1;
        if (!m_cfg[30] && n[30]) m_sts[30] = 1; else if (m_cfg[30] && !n[30]) m_sts[30] = 0;
        m_cfg = n;
      end
      32'h30: m_rtr = v & 32'h3FF8_0000;
      32'h34: m_pmt = (v & 32'hF800_0000) | 32'h07C0_0000;
      32'h40, 32'h44, 32'h48, 32'h4C: m_bank[(off - 32'h40) >> 2] = v & 32'hFFDE_E001;
      32'h94: m_ecfg = v & 32'h00F0_0000;
      32'h98: m_eesr = v & 32'hFFF0_F000;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_rd(input logic [31:0] off);
    case (off)
      32'h00: return m_esr0;
      32'h08: return m_esr1;
      32'h10: return m_eadr;
      32'h20: return m_cfg;
      32'h24: return m_sts;
      32'h30: return m_rtr;
      32'h34: return m_pmt;
      32'h40, 32'h44, 32'h48, 32'h4C: return m_bank[(off - 32'h40) >> 2];
      32'h94: return m_ecfg;
      32'h98: return m_eesr;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] model_hit(input logic [31:0] a);
    longint unsigned base, size;
    for (int b = 0; b < 4; b++) begin
      base = longint'(m_bank[b] & 32'hFF80_0000);
      size = 64'h40_0000 << m_bank[b][19:17];
      if (m_cfg[31] && m_bank[b][0] && m_bank[b][19:17] != 3'd7 &&
          longint'(a) >= base && longint'(a) < base + size)
        return 4'b1 << b;
    end
    return 4'b0;
  endfunction

  task automatic bus_wr(input logic [9:0] r, input logic [31:0] d);
    @(negedge clk); wr_i = 1; regno_i = r; wdata_i = d;
    @(negedge clk); wr_i = 0;
  endtask

  task automatic bus_rd(input logic [9:0] r, output logic [31:0] d);
    @(negedge clk); rd_i = 1; regno_i = r;
    @(negedge clk); rd_i = 0; d = rdata_o;
  endtask

  task automatic ireg_wr(input logic [31:0] off, input logic [31:0] v);
    bus_wr(RA, off); bus_wr(RD, v); model_wr(off, v);
  endtask

  task automatic ireg_rd(input logic [31:0] off, output logic [31:0] d);
    bus_wr(RA, off); bus_rd(RD, d);
  endtask

  task automatic chk_hit(input string req, input logic [31:0] a);
    sys_addr_i = a; #(CLK_PERIOD/4);
    chk(req, {28'b0, hit_o}, {28'b0, model_hit(a)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v;
    model_reset();
    repeat (4) @(negedge clk);
    rst_ni = 1;

    // R9 reset state
    chk("R9 irq", {31'b0, ecc_irq_o}, 0);
    chk("R9 hit", {28'b0, hit_o}, 0);
    bus_rd(RA, d); chk("R9 offset", d, 0);
    for (int o = 0; o < 32'hA0; o += 4) begin
      ireg_rd(o, d); chk($sformatf("R9 off %0h", o), d, model_rd(o));
    end

    // R1 offset readback, foreign register numbers
    bus_wr(RA, 32'h1234_5678); bus_rd(RA, d); chk("R1 offset readback", d, 32'h1234_5678);
    bus_rd(RD, d); chk("R1 odd offset", d, 32'hFFFF_FFFF);
    bus_rd(10'h012, d); chk("R1 foreign read", d, 0);
    bus_wr(10'h012, 32'h10); bus_rd(RA, d); chk("R1 foreign write", d, 32'h1234_5678);
    @(negedge clk); chk("R1 rdata hold", rdata_o, 32'h1234_5678);

    // R2 R3 R6 R7 R8 sweep every offset 0..0xFF
    for (int o = 0; o < 256; o++) begin
      v = 32'hDEAD_BEEF ^ (o * 32'h0101_0101);
      ireg_wr(o, v);
      chk($sformatf("R8 irq after off %0h", o), {31'b0, ecc_irq_o}, {31'b0, m_eesr != 0});
      ireg_rd(o, d);
      chk($sformatf("R2 map off %0h", o), d, model_rd(o));
    end

    // R6 status ignores writes, eadr plain
    ireg_rd(32'h24, v); ireg_wr(32'h24, ~v); ireg_rd(32'h24, d); chk("R6 status ro", d, v);
    ireg_wr(32'h10, 32'hCAFE_0001); ireg_rd(32'h10, d); chk("R6 eadr", d, 32'hCAFE_0001);
    ireg_wr(32'h00, 32'hFFFF_FFFF); ireg_rd(32'h00, d); chk("R6 esr0 w1c", d, 0);

    // R4 R5 config edges
    ireg_wr(32'h20, 32'h0); ireg_wr(32'h20, 32'h8000_0000);
    ireg_rd(32'h24, d); chk("R4 enable clears sts31", {31'b0, d[31]}, 0);
    ireg_wr(32'h20, 32'h0);
    ireg_rd(32'h24, d); chk("R4 disable sets sts31", {31'b0, d[31]}, 1);
    ireg_wr(32'h20, 32'h4000_0000);
    ireg_rd(32'h24, d); chk("R5 self bit set", {31'b0, d[30]}, 1);
    ireg_wr(32'h20, 32'h001F_FFFF);
    ireg_rd(32'h24, d); chk("R5 self bit clear", {31'b0, d[30]}, 0);
    ireg_rd(32'h20, d); chk("R4 cfg mask", d, 0);

    // R7 explicit masks
    ireg_wr(32'h34, 32'h0); ireg_rd(32'h34, d); chk("R7 pmt", d, 32'h07C0_0000);
    ireg_wr(32'h30, 32'hFFFF_FFFF); ireg_rd(32'h30, d); chk("R7 rtr", d, 32'h3FF8_0000);
    ireg_wr(32'h94, 32'hFFFF_FFFF); ireg_rd(32'h94, d); chk("R7 ecfg", d, 32'h00F0_0000);

    // R8 irq edges
    ireg_wr(32'h98, 32'h0); chk("R8 irq low", {31'b0, ecc_irq_o}, 0);
    ireg_wr(32'h98, 32'h000F_0FFF); chk("R8 masked zero", {31'b0, ecc_irq_o}, 0);
    ireg_wr(32'h98, 32'h0010_0000); chk("R8 irq rise", {31'b0, ecc_irq_o}, 1);
    ireg_rd(32'h98, d); chk("R8 eesr value", d, 32'h0010_0000);
    ireg_wr(32'h98, 32'h0); chk("R8 irq fall", {31'b0, ecc_irq_o}, 0);

    // R3 bank word mask
    ireg_wr(32'h44, 32'hFFFF_FFFF); ireg_rd(32'h44, d); chk("R3 bank mask", d, 32'hFFDE_E001);

    // R10 R11 hit sweep over size codes, enables and overlaps
    ireg_wr(32'h20, 32'h8000_0000);
    for (int s = 0; s < 8; s++) begin
      for (int b = 0; b < 4; b++)
        ireg_wr(32'h40 + 4*b, (b * 32'h0400_0000) | (((s + b) % 8) << 17) |
                ((s + b) % 5 != 4 ? 1 : 0));
      for (int k = 0; k < 128; k++) begin
        chk_hit($sformatf("R10 R11 set %0d lo", s), (k << 22));
        chk_hit($sformatf("R10 R11 set %0d hi", s), (k << 22) | 32'h003F_FFFC);
      end
    end

    // R12 bank write visible next cycle
    ireg_wr(32'h40, 32'h0); sys_addr_i = 32'h0010_0000;
    ireg_wr(32'h40, 32'h0000_0001);
    chk("R12 hit after write", {28'b0, hit_o}, 4'b0001);

    // R10 global disable
    ireg_wr(32'h20, 32'h0);
    chk("R10 disabled no hit", {28'b0, hit_o}, 0);
    for (int k = 0; k < 16; k++) chk_hit("R10 disabled sweep", k << 24);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule